// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block performs signed saturating arithmetic on 32-bit two's-complement operands. It offers three register forms (add, subtract and reverse subtract) and two immediate forms (add with a short sign-extended immediate, and subtract with a long sign-extended immediate). When the exact result does not fit in 32 signed bits, the output is pinned to the largest or smallest representable value. The condition flags are then rebuilt from the operation. A saturation flag records that clamping happened and keeps that record across later operations.

A pipeline stage in an execute unit places the two register values, the immediate field, the operation code and the present status flags on the inputs, and pulses `start`. One clock later the result and the new flags sit in output registers, and `valid` is high for that single cycle. Register-file access, instruction decoding and writing the status register back are left to the surrounding logic.

Top module: `sat_arith_unit`

## Requirements
- R1: After reset, `result` is 0, `flagsOut` is 0 and `valid` is low.
- R2: When `start` is high at a rising edge with a legal operation code (0 to 4), `result` and `flagsOut` take the new values at that edge, and `valid` is high for exactly the following cycle.
- R3: Register forms, with `srcReg1` as reg1 and `srcReg2` as reg2: code 0 gives reg2 + reg1, code 1 gives reg2 − reg1, code 2 gives reg1 − reg2.
- R4: Code 3 gives reg2 + sign-extend(`immField[4:0]`), and the upper immediate bits are ignored. Code 4 gives reg2 − sign-extend(`immField[15:0]`).
- R5: When the exact result is above the signed maximum, `result` is 32'h7FFF_FFFF.
- R6: When the exact result is below the signed minimum, `result` is 32'h8000_0000.
- R7: Flag bit positions are the same in `flagsIn` and `flagsOut`: [0] zero, [1] sign, [2] carry, [3] overflow, [4] saturation. Zero and sign describe the final, possibly clamped, result.
- R8: Carry is the unsigned carry out of an add, or the unsigned borrow (minuend < subtrahend) of a subtract. Overflow is the signed overflow of the unclamped result. Both are recomputed on every operation.
- R9: Saturation is set whenever clamping occurs. Otherwise it copies `flagsIn[4]`, so these operations never clear it.
- R10: With `start` low, or with an operation code of 5, 6 or 7, `result` and `flagsOut` hold their values and `valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation this cycle |
| opSel | input | 3 | Operation code, 0 to 4 are legal |
| srcReg1 | input | 32 | First register operand (reg1) |
| srcReg2 | input | 32 | Second register operand (reg2) |
| immField | input | 16 | Immediate field; short form uses bits [4:0] |
| flagsIn | input | 5 | Current status flags |
| result | output | 32 | Registered, possibly clamped, result |
| flagsOut | output | 5 | Registered updated flags |
| valid | output | 1 | High for one cycle after an accepted start |

## Verification
Several rules are checked by properties on every cycle. An overflowed result always lies on one of the two clamp values, and overflow always comes with saturation set. A set saturation input always survives an accepted operation. Outputs stay unchanged while nothing is accepted, and `valid` follows an accepted start by exactly one cycle. Only the directed scenarios can show the actual arithmetic: the operand order of the reverse form, sign extension of each immediate, the exact carry and borrow values, and which clamp value each overflow direction selects.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

  localparam int DATA_W   = 32;
  localparam int IMM_S_W  = 5;
  localparam int IMM_L_W  = 16;
  localparam int OP_W     = 3;
  localparam int FLAG_W   = 5;

  // flag bit positions shared by flagsIn and flagsOut
  localparam int FLG_Z   = 0;
  localparam int FLG_S   = 1;
  localparam int FLG_CY  = 2;
  localparam int FLG_OV  = 3;
  localparam int FLG_SAT = 4;

  localparam logic [OP_W-1:0] OPC_ADD_RR   = 3'd0;
  localparam logic [OP_W-1:0] OPC_SUB_RR   = 3'd1;
  localparam logic [OP_W-1:0] OPC_RSUB_RR  = 3'd2;
  localparam logic [OP_W-1:0] OPC_ADD_IMMS = 3'd3;
  localparam logic [OP_W-1:0] OPC_SUB_IMML = 3'd4;

  typedef struct packed {
    logic load;        // capture a new result
    logic useImmShort; // second operand from short immediate
    logic useImmLong;  // second operand from long immediate
    logic swapOps;     // reverse operand order
    logic subtract;    // subtract instead of add
  } arithStrobe_t;

endpackage

// File: rtl/sat_arith_ctrl.sv
module sat_arith_ctrl
  import sat_arith_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opSel,
  output arithStrobe_t    stb
);

  always_comb begin
    stb = '0;
    unique case (opSel)
      OPC_ADD_RR:   stb.load = start;
      OPC_SUB_RR:   begin stb.load = start; stb.subtract = 1'b1; end
      OPC_RSUB_RR:  begin stb.load = start; stb.subtract = 1'b1; stb.swapOps = 1'b1; end
      OPC_ADD_IMMS: begin stb.load = start; stb.useImmShort = 1'b1; end
      OPC_SUB_IMML: begin stb.load = start; stb.useImmLong = 1'b1; stb.subtract = 1'b1; end
      default:      stb = '0;
    endcase
  end

  AST_ONE_IMM_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.useImmShort, stb.useImmLong})); // R4

  AST_ILLEGAL_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > OPC_SUB_IMML) |-> !stb.load); // R10

endmodule

// File: rtl/sat_arith_dp.sv
module sat_arith_dp
  import sat_arith_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int IMS = IMM_S_W,
  parameter int IML = IMM_L_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  arithStrobe_t      stb,
  input  logic [W-1:0]      reg1,
  input  logic [W-1:0]      reg2,
  input  logic [IML-1:0]    immVal,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [W-1:0]      resultQ,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              validQ
);

  localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]      immShortExt, immLongExt, srcB, lhs, rhs, clamped;
  logic [W:0]        wide, unsignedSum;
  logic              carryBit, ovf;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    immShortExt = {{(W-IMS){immVal[IMS-1]}}, immVal[IMS-1:0]};
    immLongExt  = {{(W-IML){immVal[IML-1]}}, immVal};
    if (stb.useImmShort)     srcB = immShortExt;
    else if (stb.useImmLong) srcB = immLongExt;
    else                     srcB = reg1;
    lhs = stb.swapOps ? srcB : reg2;
    rhs = stb.swapOps ? reg2 : srcB;
  end

  // one sign bit of headroom keeps the exact result
  always_comb begin
    if (stb.subtract) begin
      wide        = {lhs[W-1], lhs} - {rhs[W-1], rhs};
      unsignedSum = '0;
      carryBit    = (lhs < rhs);
    end else begin
      wide        = {lhs[W-1], lhs} + {rhs[W-1], rhs};
      unsignedSum = {1'b0, lhs} + {1'b0, rhs};
      carryBit    = unsignedSum[W];
    end
    ovf = wide[W] ^ wide[W-1];
    if (!ovf)         clamped = wide[W-1:0];
    else if (wide[W]) clamped = SAT_MIN;
    else              clamped = SAT_MAX;
  end

  always_comb begin
    flagsNext          = '0;
    flagsNext[FLG_Z]   = (clamped == '0);
    flagsNext[FLG_S]   = clamped[W-1];
    flagsNext[FLG_CY]  = carryBit;
    flagsNext[FLG_OV]  = ovf;
    flagsNext[FLG_SAT] = flagsIn[FLG_SAT] | ovf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= stb.load;
      if (stb.load) begin
        resultQ <= clamped;
        flagsQ  <= flagsNext;
      end
    end
  end

  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && flagsQ[FLG_OV]) |-> (resultQ == SAT_MAX || resultQ == SAT_MIN)); // R5

  AST_SAT_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && flagsQ[FLG_OV]) |-> flagsQ[FLG_SAT]); // R9

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && flagsIn[FLG_SAT]) |=> flagsQ[FLG_SAT]); // R9

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && flagsQ[FLG_Z]) |-> (resultQ == '0 && !flagsQ[FLG_S])); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(resultQ) && $stable(flagsQ))); // R10

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] srcReg1,
  input  logic [DATA_W-1:0] srcReg2,
  input  logic [IMM_L_W-1:0] immField,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              valid
);

  arithStrobe_t stb;

  sat_arith_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .stb   (stb)
  );

  sat_arith_dp #(
    .W   (DATA_W),
    .IMS (IMM_S_W),
    .IML (IMM_L_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reg1    (srcReg1),
    .reg2    (srcReg2),
    .immVal  (immField),
    .flagsIn (flagsIn),
    .resultQ (result),
    .flagsQ  (flagsOut),
    .validQ  (valid)
  );

  AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel <= OPC_SUB_IMML) |=> valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(start && opSel <= OPC_SUB_IMML) |=> !valid); // R10

endmodule

// File: tb/sat_arith_unit_test.sv
module sat_arith_unit_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] srcReg1 = '0, srcReg2 = '0;
  logic [15:0] immField = '0;
  logic [4:0]  flagsIn = '0;
  logic [31:0] result;
  logic [4:0]  flagsOut;
  logic        valid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_arith_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcReg1(srcReg1), .srcReg2(srcReg2), .immField(immField),
    .flagsIn(flagsIn), .result(result), .flagsOut(flagsOut), .valid(valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one op; expected values written by hand (flags: {sat,ov,cy,s,z})
  task automatic runOp(string req, logic [2:0] op, logic [31:0] r1, logic [31:0] r2,
                       logic [15:0] imm, logic [4:0] fin,
                       logic [31:0] expRes, logic [4:0] expFlags);
    @(negedge clk);
    opSel = op; srcReg1 = r1; srcReg2 = r2; immField = imm; flagsIn = fin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " valid"}, {31'd0, valid}, 32'd1);
    check({req, " result"}, result, expRes);
    check({req, " flags"}, {27'd0, flagsOut}, {27'd0, expFlags});
    @(negedge clk);
    check({req, " valid drop R2"}, {31'd0, valid}, 32'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 flags", {27'd0, flagsOut}, 32'd0);
    check("R1 valid", {31'd0, valid}, 32'd0);
  endtask

  task automatic testRegForms();
    runOp("R3 add", 3'd0, 32'd5, 32'd7, 16'd0, 5'b0, 32'd12, 5'b00000);
    runOp("R3 sub", 3'd1, 32'd3, 32'd3, 16'd0, 5'b0, 32'd0, 5'b00001);
    // reg1 - reg2 = 5 - 7 : borrow, negative
    runOp("R3 rsub R8", 3'd2, 32'd5, 32'd7, 16'd0, 5'b0, 32'hFFFF_FFFE, 5'b00110);
    // 0xFFFFFFFF + 1 = 0 with unsigned carry, no signed overflow
    runOp("R8 carry", 3'd0, 32'd1, 32'hFFFF_FFFF, 16'd0, 5'b0, 32'd0, 5'b00101);
  endtask

  task automatic testImmForms();
    // 10 + sext(0x1F) = 9, carry out
    runOp("R4 imm5", 3'd3, 32'd0, 32'd10, 16'h001F, 5'b0, 32'd9, 5'b00100);
    // upper bits ignored: low five bits 0x02
    runOp("R4 imm5 upper", 3'd3, 32'd0, 32'd10, 16'hFFE2, 5'b0, 32'd12, 5'b00000);
    // 100 - sext(0xFFFF) = 101, borrow since 100 < 0xFFFFFFFF
    runOp("R4 imm16", 3'd4, 32'd0, 32'd100, 16'hFFFF, 5'b0, 32'd101, 5'b00100);
  endtask

  task automatic testOverflow();
    runOp("R5 pos add", 3'd0, 32'd1, 32'h7FFF_FFFF, 16'd0, 5'b0, 32'h7FFF_FFFF, 5'b11000);
    runOp("R6 neg add", 3'd0, 32'hFFFF_FFFF, 32'h8000_0000, 16'd0, 5'b0, 32'h8000_0000, 5'b11110);
    runOp("R6 neg sub", 3'd1, 32'd1, 32'h8000_0000, 16'd0, 5'b0, 32'h8000_0000, 5'b11010);
    // 0x7FFFFFFF - (-32768) overflows positive; borrow since unsigned lhs < 0xFFFF8000
    runOp("R5 imm16", 3'd4, 32'd0, 32'h7FFF_FFFF, 16'h8000, 5'b0, 32'h7FFF_FFFF, 5'b11100);
    // reverse: reg1=0x80000000 minus reg2=1
    runOp("R6 rsub", 3'd2, 32'h8000_0000, 32'd1, 16'd0, 5'b0, 32'h8000_0000, 5'b11010);
  endtask

  task automatic testSticky();
    runOp("R9 keep", 3'd0, 32'd1, 32'd2, 16'd0, 5'b10000, 32'd3, 5'b10000);
    // stale Z/S/CY/OV inputs do not leak through
    runOp("R8 rewrite", 3'd0, 32'd1, 32'd2, 16'd0, 5'b01111, 32'd3, 5'b00000);
  endtask

  task automatic testIllegal();
    runOp("R10 setup", 3'd0, 32'd20, 32'd22, 16'd0, 5'b0, 32'd42, 5'b00000);
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      opSel = 3'(c); srcReg1 = 32'd1; srcReg2 = 32'd1; flagsIn = 5'b11111; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 illegal valid", {31'd0, valid}, 32'd0);
      check("R10 illegal result", result, 32'd42);
      check("R10 illegal flags", {27'd0, flagsOut}, 32'd0);
    end
    @(negedge clk);
    opSel = 3'd0; srcReg1 = 32'd7; srcReg2 = 32'd7; start = 1'b0;
    @(negedge clk);
    check("R10 idle valid", {31'd0, valid}, 32'd0);
    check("R10 idle result", result, 32'd42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegForms();
    testImmForms();
    testOverflow();
    testSticky();
    testIllegal();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule